// File: doc/BRIEF.md
# Infrared Carrier Burst Timer

This block shapes the modulated output of an infrared remote-control transmitter. Each write of a 10-bit timer word starts a timed interval. The low nine bits give the interval length, counted in prescaler ticks. The top bit decides whether a carrier square wave is driven onto the LED output for that interval or the output is held low. A sequence of such writes builds a transmission frame from marks (bursts) and spaces (gaps).

A free-running prescaler produces one tick every eight clocks, and the interval counts down on these ticks. A separate free-running divider makes the carrier at the clock divided by 8, or by 12 with either half or one-third duty. An active-low busy line tracks the carrier gate. A one-clock completion pulse can wake a waiting controller. That controller may write the next word on the completion edge itself and the output continues without a break.

Top module: `ir_burst_timer`

## Requirements
- R1: The prescaler ticks on every clock edge whose index since reset release is a multiple of 8 (edges numbered 1, 2, ... after the release). Only ticks decrement the interval.
- R2: A load of count N on edge E makes the interval active from E. The interval ends on the (N+1)-th tick edge strictly after E. A count of zero therefore lasts until the first tick after the load.
- R3: Word bit 9 is the carrier gate. With bit 9 = 1, busy_n is low for the whole active interval. With bit 9 = 0, busy_n stays high and rem_out stays low, and completion is still signalled.
- R4: With div_sel = 0 the carrier period is 8 clocks at duty 1/2. rem_out is high after edge k exactly when (k mod 8) < 4, and duty_third has no effect.
- R5: With div_sel = 1 the carrier period is 12 clocks. rem_out is high when (k mod 12) < 6 if duty_third = 0, and when (k mod 12) < 4 if duty_third = 1.
- R6: busy_n is low exactly while the carrier is gated onto rem_out, and rem_out is never high while busy_n is high.
- R7: Completion is a single-clock done_pulse, asserted after the final tick edge. After that edge rem_out is low and busy_n is high.
- R8: While run is low, tick edges are not counted and the interval is frozen. Counting resumes when run returns high.
- R9: A load takes priority over the decrement in the same cycle. A load on the completion edge gives no done_pulse, and busy_n stays low without a gap.
- R10: An asynchronous reset clears the whole timer word. It drives rem_out low, busy_n high and done_pulse low. No interval runs again until a new load.
- R11: The carrier phase depends only on the clock edges since reset, never on the load time. The first and last carrier pulses of a burst may therefore be cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Timer word write strobe |
| ld_word | input | 10 | Bit 9 carrier gate, bits 8:0 interval count |
| run | input | 1 | 1 counts, 0 freezes the interval |
| div_sel | input | 1 | Carrier divide: 0 by 8, 1 by 12 |
| duty_third | input | 1 | Duty at divide by 12: 0 half, 1 one third |
| rem_out | output | 1 | Gated carrier to the LED driver |
| busy_n | output | 1 | Low while the carrier is gated on |
| done_pulse | output | 1 | One-clock interval completion |

## Verification
The bench predicts, clock by clock, the busy window, the carrier level and the completion edge from the edge count since reset. A design that restarted the carrier or prescaler on a load would show shifted carrier edges or a wrong interval length. A design that let the decrement win over a reload at the completion edge would produce a stray done_pulse and a one-cycle busy gap. The bench also freezes counting across two ticks, which catches a design that ignores run, and it uses a zero count, which catches an off-by-one in the end test. It also sets the one-third option in divide-by-8 mode, which catches a design that lets that option leak in.

// File: rtl/ir_burst_timer.sv
module ir_burst_timer #(
  parameter int CNT_W    = 9,
  parameter int PRE_LOG2 = 3,
  parameter int DIV_LO   = 8,
  parameter int DIV_HI   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [CNT_W:0] ld_word,
  input  logic           run,
  input  logic           div_sel,
  input  logic           duty_third,
  output logic           rem_out,
  output logic           busy_n,
  output logic           done_pulse
);
  localparam int CW = $clog2(DIV_HI);
  localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] HALF_LO = CW'(DIV_LO / 2);
  localparam logic [CW-1:0] HALF_HI = CW'(DIV_HI / 2);
  localparam logic [CW-1:0] THIRD_HI = CW'(DIV_HI / 3);

  logic [PRE_LOG2-1:0] pre;
  logic [CW-1:0]       car;
  logic [CNT_W-1:0]    cnt;
  logic                gate, active, done_q;

  wire tick     = &pre;
  wire car_last = div_sel ? (car >= LAST_HI) : (car >= LAST_LO);
  wire car_hi   = div_sel ? (car < (duty_third ? THIRD_HI : HALF_HI)) : (car < HALF_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      car <= '0;
    end else begin
      pre <= pre + 1'b1;
      car <= car_last ? '0 : car + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      gate   <= 1'b0;
      active <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld_en) begin
        cnt    <= ld_word[CNT_W-1:0];
        gate   <= ld_word[CNT_W];
        active <= 1'b1;
      end else if (active && run && tick) begin
        if (cnt == '0) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign rem_out    = active & gate & car_hi;
  assign busy_n     = ~(active & gate);
  assign done_pulse = done_q;
endmodule

module ir_burst_timer_chk #(
  parameter int CNT_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_en,
  input logic [CNT_W:0] ld_word,
  input logic           run,
  input logic           rem_out,
  input logic           busy_n,
  input logic           done_pulse
);
  // R6
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !rem_out);
  // R7
  done_frees_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> busy_n);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  // R3
  gated_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_word[CNT_W]) |=> !busy_n);
  // R3
  ungated_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_word[CNT_W]) |=> busy_n);
  // R8
  frozen_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done_pulse);
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !done_pulse);
endmodule

bind ir_burst_timer ir_burst_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word), .run(run),
  .rem_out(rem_out), .busy_n(busy_n), .done_pulse(done_pulse)
);

// File: tb/tb_ir_burst_timer.sv
module tb_ir_burst_timer;
  logic clk = 0, rst_n = 0, ld_en = 0, run = 1, div_sel = 0, duty_third = 0;
  logic [9:0] ld_word = '0;
  logic rem_out, busy_n, done_pulse;
  int checks = 0, errors = 0, ecnt = 0;

  ir_burst_timer dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_word(ld_word), .run(run),
    .div_sel(div_sel), .duty_third(duty_third),
    .rem_out(rem_out), .busy_n(busy_n), .done_pulse(done_pulse)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0; else ecnt <= ecnt + 1;

  // {div_sel, duty_third, gate, count[8:0]}
  localparam logic [11:0] VEC [0:6] = '{
    {2'b00, 10'h203}, {2'b10, 10'h205}, {2'b11, 10'h204}, {2'b00, 10'h003},
    {2'b11, 10'h200}, {2'b01, 10'h202}, {2'b10, 10'h001}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit car_exp(input int k, input bit dv, input bit th);
    int p = dv ? 12 : 8;
    int h = dv ? (th ? 4 : 6) : 4;
    return (k % p) < h;
  endfunction

  function automatic int first_td(input int e, input int n);
    return ((e / 8) + 1) * 8 + 8 * n;
  endfunction

  task automatic do_reset(input bit dv, input bit th);
    @(negedge clk);
    rst_n = 0; ld_en = 0; run = 1; div_sel = dv; duty_third = th;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(input logic [9:0] w, output int e);
    ld_en = 1; ld_word = w; e = ecnt + 1;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic observe(input int e0, input int td, input bit g, input bit dv, input bit th, input string tag);
    int bb = 0, br = 0, bd = 0, kb = 0, kr = 0, kd = 0;
    while (ecnt <= td + 1) begin
      int k = ecnt;
      bit act = (k >= e0) && (k < td);
      bit eb = !(act && g);
      bit er = act && g && car_exp(k, dv, th);
      bit ed = (k == td);
      if (busy_n !== eb) begin if (bb == 0) kb = k; bb++; end
      if (rem_out !== er) begin if (br == 0) kr = k; br++; end
      if (done_pulse !== ed) begin if (bd == 0) kd = k; bd++; end
      @(negedge clk);
    end
    chk(bb == 0, {tag, " R2 R3"}, "busy_n mismatches (first edge in expected)", bb, kb);
    chk(br == 0, {tag, " R4 R5 R11"}, "rem_out mismatches (first edge in expected)", br, kr);
    chk(bd == 0, {tag, " R7"}, "done_pulse mismatches (first edge in expected)", bd, kd);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, td;
    // R10 reset state
    #5;
    chk(rem_out === 0 && busy_n === 1 && done_pulse === 0, "R10", "outputs in reset", {rem_out, busy_n, done_pulse}, 3'b010);

    for (int i = 0; i < 7; i++) begin
      logic [11:0] v = VEC[i];
      do_reset(v[11], v[10]);
      repeat (i * 3 + 1) @(negedge clk);
      load(v[9:0], e);
      observe(e, first_td(e, int'(v[8:0])), v[9], v[11], v[10], $sformatf("vec%0d R1", i));
    end

    // R8 freeze for 16 clocks
    do_reset(0, 0);
    repeat (5) @(negedge clk);
    load(10'h204, e);
    td = first_td(e, 4) + 16;
    fork
      observe(e, td, 1, 0, 0, "freeze R8");
      begin
        while (ecnt != e + 2) @(negedge clk);
        run = 0;
        repeat (16) @(negedge clk);
        run = 1;
      end
    join

    // R9 reload on the completion edge
    do_reset(1, 0);
    repeat (3) @(negedge clk);
    load(10'h201, e);
    td = first_td(e, 1);
    fork
      observe(e, td + 16, 1, 1, 0, "reload R9");
      begin
        while (ecnt != td - 1) @(negedge clk);
        ld_en = 1; ld_word = 10'h201;
        @(negedge clk);
        ld_en = 0;
      end
    join

    // R10 reset mid-burst then stays idle
    do_reset(0, 0);
    repeat (2) @(negedge clk);
    load(10'h20A, e);
    repeat (5) @(negedge clk);
    chk(busy_n === 0, "R10", "busy before reset", busy_n, 0);
    rst_n = 0;
    #1;
    chk(rem_out === 0 && busy_n === 1 && done_pulse === 0, "R10", "outputs after async reset", {rem_out, busy_n, done_pulse}, 3'b010);
    @(negedge clk);
    rst_n = 1;
    begin
      int bad = 0;
      for (int j = 0; j < 120; j++) begin
        @(negedge clk);
        if (busy_n !== 1 || rem_out !== 0 || done_pulse !== 0) bad++;
      end
      chk(bad == 0, "R10", "activity after reset without load", bad, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule